// File: doc/BRIEF.md
# UART Host Register and Command Interface

This block is the register front end of a simple serial port. A byte-wide host bus reaches a 64-byte window through a six-bit address, and the block turns those accesses into control for an external serial datapath. Control covers transmit and receive enables, a held transmit byte with a load strobe, one-cycle reset pulses for both directions, and a pop strobe for the receive FIFO. The block also gathers receiver status and error events into a status byte, and it builds an interrupt status byte. One level interrupt output is raised whenever an unmasked interrupt source is active.

A single command byte carries three independent sub-commands. A miscellaneous action sits in bits [6:4], a transmitter enable field in bits [3:2] and a receiver enable field in bits [1:0]. Two mode bytes share one address, and a pointer that advances after the first access selects between them. A bit in the first mode byte decides whether the receive interrupt follows "data available" or "FIFO full". Writes to the clock-select offset (0x04) and the auxiliary-control offset (0x10) are accepted and have no effect.

Register map, all other offsets reading 0:

- 0x00: mode byte selected by the pointer.
- 0x04: status on read.
- 0x08: command on write.
- 0x0C: receive head on read, transmit byte on write.
- 0x14: interrupt status on read, interrupt mask on write.

Top module: `uart_regif`

## Requirements
- R1: After reset the status byte (0x04) reads 0x08 (only TxEMP, bit3), the interrupt status byte (0x14) reads 0x00, `irq`, `tx_en`, `rx_en` and `bad_cmd` are low, and the mode pointer selects the first mode byte.
- R2: The first access (read or write) at 0x00 after reset, or after a command whose bits [6:4] equal 1, reaches mode byte 1. Every later access reaches mode byte 2 until the next such command.
- R3: A write at 0x0C stores the byte on `tx_data` and clears TxEMP (status bit3). While the transmitter is enabled, a pending byte raises `tx_load` for exactly one cycle and TxEMP is set again. While the transmitter is disabled, the byte stays pending with TxEMP low and `tx_load` low.
- R4: TxRDY (status bit2) is high exactly when the transmitter is enabled and TxEMP is high.
- R5: In a command byte, bits [3:2] drive the transmitter and bits [1:0] drive the receiver: 0 leaves the enable unchanged, 1 enables, 2 disables. Code 3 leaves the enable unchanged and sets `bad_cmd`, which stays high until reset. These fields take effect after the miscellaneous action of the same byte.
- R6: Miscellaneous code 2 pulses `rx_rst` for one cycle and disables the receiver. It also forces RxRDY (status bit0) and FFULL (status bit1) to 0 until `rx_avail` has been seen low.
- R7: Miscellaneous code 3 pulses `tx_rst` for one cycle, disables the transmitter, sets TxEMP and drops any pending byte without a load.
- R8: Outside a receiver-reset hold, status bit0 follows `rx_avail` and bit1 follows `rx_full`. The event inputs `rx_ovr_evt`, `rx_par_evt`, `rx_frm_evt` and `rx_brk_evt` set sticky status bits 4, 5, 6 and 7. Miscellaneous code 4 clears all four.
- R9: `rx_brk_evt` sets interrupt status bit2, and miscellaneous code 5 clears it. Miscellaneous codes 0, 6 and 7 change no state.
- R10: Interrupt status bit0 equals TxRDY. Bit1 equals FFULL when mode byte 1 bit6 is set, and RxRDY otherwise. Bit7 reads 0. The mask is written at 0x14, and `irq` is high exactly when (interrupt status AND mask) is nonzero.
- R11: A read at 0x0C returns `rx_head` and raises `rx_pop` in that same cycle. Reads elsewhere do not raise `rx_pop`. Writes at 0x04 and 0x10 leave the status byte and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Level interrupt |
| tx_en | output | 1 | Transmitter enabled |
| tx_load | output | 1 | Pending byte handed to serial side |
| tx_data | output | 8 | Held transmit byte |
| tx_rst | output | 1 | Transmitter reset pulse |
| rx_en | output | 1 | Receiver enabled |
| rx_rst | output | 1 | Receiver reset pulse |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_head | input | 8 | Receive FIFO head byte |
| rx_avail | input | 1 | Receive FIFO not empty |
| rx_full | input | 1 | Receive FIFO full |
| rx_ovr_evt | input | 1 | Overrun event |
| rx_par_evt | input | 1 | Parity error event |
| rx_frm_evt | input | 1 | Framing error event |
| rx_brk_evt | input | 1 | Received break event |
| bad_cmd | output | 1 | Sticky reserved-command flag |

## Verification
The receiver-reset hold is the hardest state to reach from the ports. The bench has to keep `rx_avail` high across the reset command, show that the status still reads 0, then drop `rx_avail` for a cycle and raise it again to see RxRDY return. A second hard case needs the transmitter disabled: the bench writes a byte while disabled, and only then does an enable command or a transmitter reset decide whether the byte is loaded or dropped. Random command bytes and random mask, mode and FIFO levels are then checked against a bench model of the enables, the interrupt status and `irq`.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 6;

    typedef enum logic [2:0] {
        MISC_NONE   = 3'd0,
        MISC_PTRRST = 3'd1,
        MISC_RXRST  = 3'd2,
        MISC_TXRST  = 3'd3,
        MISC_ERRRST = 3'd4,
        MISC_BRKCLR = 3'd5,
        MISC_BRKON  = 3'd6,
        MISC_BRKOFF = 3'd7
    } misc_e;

    typedef struct packed {
        misc_e misc;
        logic  tx_on;
        logic  tx_off;
        logic  rx_on;
        logic  rx_off;
        logic  bad;
    } cmd_t;

    // status byte bit positions
    localparam int ST_RXRDY = 0;
    localparam int ST_FFULL = 1;
    localparam int ST_TXRDY = 2;
    localparam int ST_TXEMP = 3;
    localparam int ST_ERR0  = 4;

    // interrupt status bit positions
    localparam int IS_TX  = 0;
    localparam int IS_RX  = 1;
    localparam int IS_BRK = 2;
    localparam int IS_COS = 7;

    localparam int MR1_RXSEL = 6;

endpackage

// File: rtl/uart_cmd_dec.sv
module uart_cmd_dec
    import uart_regif_pkg::*;
(
    input  logic [6:0] cmd_byte,
    output cmd_t       dec
);

    logic [1:0] tx_field;
    logic [1:0] rx_field;

    assign tx_field = cmd_byte[3:2];
    assign rx_field = cmd_byte[1:0];

    always_comb begin
        dec        = '0;
        dec.misc   = misc_e'(cmd_byte[6:4]);
        dec.tx_on  = (tx_field == 2'd1);
        dec.tx_off = (tx_field == 2'd2);
        dec.rx_on  = (rx_field == 2'd1);
        dec.rx_off = (rx_field == 2'd2);
        dec.bad    = (tx_field == 2'd3) || (rx_field == 2'd3);
    end

endmodule

// File: rtl/uart_tx_ctl.sv
module uart_tx_ctl
    import uart_regif_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  misc_e             misc,
    input  logic              en_on,
    input  logic              en_off,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_en,
    output logic              tx_emp,
    output logic              tx_rdy,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_rst
);

    typedef struct packed {
        logic              en;
        logic              emp;
        logic              rst_pls;
        logic [DATA_W-1:0] hold;
    } tx_state_t;

    tx_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.rst_pls = 1'b0;
        if (s_q.en && !s_q.emp) begin
            s_d.emp = 1'b1;
        end
        if (wr_valid) begin
            s_d.hold = wr_data;
            s_d.emp  = 1'b0;
        end
        if (cmd_valid) begin
            if (misc == MISC_TXRST) begin
                s_d.emp     = 1'b1;
                s_d.en      = 1'b0;
                s_d.rst_pls = 1'b1;
            end
            if (en_on) begin
                s_d.en = 1'b1;
            end else if (en_off) begin
                s_d.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.emp <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_en   = s_q.en;
    assign tx_emp  = s_q.emp;
    assign tx_rdy  = s_q.en & s_q.emp;
    assign tx_load = s_q.en & ~s_q.emp;
    assign tx_data = s_q.hold;
    assign tx_rst  = s_q.rst_pls;

endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
    import uart_regif_pkg::*;
#(
    parameter int ERR_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  misc_e            misc,
    input  logic             en_on,
    input  logic             en_off,
    input  logic             rx_avail,
    input  logic             rx_full,
    input  logic [ERR_N-1:0] err_evt,
    input  logic             brk_evt,
    output logic             rx_en,
    output logic             rx_rdy,
    output logic             rx_ffull,
    output logic [ERR_N-1:0] err_flags,
    output logic             brk_int,
    output logic             rx_rst
);

    typedef struct packed {
        logic             en;
        logic             hold;
        logic             brk;
        logic             rst_pls;
        logic [ERR_N-1:0] err;
    } rx_state_t;

    rx_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.rst_pls = 1'b0;
        if (s_q.hold && !rx_avail) begin
            s_d.hold = 1'b0;
        end
        if (cmd_valid) begin
            unique case (misc)
                MISC_RXRST: begin
                    s_d.hold    = 1'b1;
                    s_d.en      = 1'b0;
                    s_d.rst_pls = 1'b1;
                end
                MISC_ERRRST: s_d.err = '0;
                MISC_BRKCLR: s_d.brk = 1'b0;
                default: ;
            endcase
            if (en_on) begin
                s_d.en = 1'b1;
            end else if (en_off) begin
                s_d.en = 1'b0;
            end
        end
        s_d.err = s_d.err | err_evt;
        if (brk_evt) begin
            s_d.brk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_en     = s_q.en;
    assign rx_rdy    = rx_avail & ~s_q.hold;
    assign rx_ffull  = rx_full & ~s_q.hold;
    assign err_flags = s_q.err;
    assign brk_int   = s_q.brk;
    assign rx_rst    = s_q.rst_pls;

endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int          DATA_W   = BYTE_W,
    parameter int          ADDR_W   = OFS_W,
    parameter int          MODE_N   = 2,
    parameter logic [5:0]  OFS_MODE = 6'h00,
    parameter logic [5:0]  OFS_STAT = 6'h04,
    parameter logic [5:0]  OFS_CMD  = 6'h08,
    parameter logic [5:0]  OFS_DATA = 6'h0C,
    parameter logic [5:0]  OFS_AUX  = 6'h10,
    parameter logic [5:0]  OFS_INT  = 6'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              tx_en,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_rst,
    output logic              rx_en,
    output logic              rx_rst,
    output logic              rx_pop,
    input  logic [DATA_W-1:0] rx_head,
    input  logic              rx_avail,
    input  logic              rx_full,
    input  logic              rx_ovr_evt,
    input  logic              rx_par_evt,
    input  logic              rx_frm_evt,
    input  logic              rx_brk_evt,
    output logic              bad_cmd
);

    localparam int PTR_W = (MODE_N > 1) ? $clog2(MODE_N) : 1;
    localparam int ERR_N = 4;

    typedef struct packed {
        logic [MODE_N-1:0][DATA_W-1:0] mode;
        logic [PTR_W-1:0]              ptr;
        logic [DATA_W-1:0]             imr;
        logic                          bad;
    } top_state_t;

    top_state_t s_d, s_q;

    logic       wr, rd;
    logic       hit_mode, hit_stat, hit_cmd, hit_data, hit_int;
    cmd_t       dec;
    logic       cmd_valid;

    logic       tx_emp, tx_rdy;
    logic       rx_rdy, rx_ffull, brk_int;
    logic [ERR_N-1:0] err_flags;
    logic [7:0] stat_byte, isr_byte;
    logic [DATA_W-1:0] imr_q;

    assign wr = bus_sel & bus_we;
    assign rd = bus_sel & ~bus_we;

    assign hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
    assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
    assign hit_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
    assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
    assign hit_int  = (bus_addr == ADDR_W'(OFS_INT));

    assign cmd_valid = wr & hit_cmd;

    uart_cmd_dec u_dec (
        .cmd_byte (bus_wdata[6:0]),
        .dec      (dec)
    );

    uart_tx_ctl #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .misc      (dec.misc),
        .en_on     (dec.tx_on),
        .en_off    (dec.tx_off),
        .wr_valid  (wr & hit_data),
        .wr_data   (bus_wdata),
        .tx_en     (tx_en),
        .tx_emp    (tx_emp),
        .tx_rdy    (tx_rdy),
        .tx_load   (tx_load),
        .tx_data   (tx_data),
        .tx_rst    (tx_rst)
    );

    uart_rx_stat #(.ERR_N(ERR_N)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .misc      (dec.misc),
        .en_on     (dec.rx_on),
        .en_off    (dec.rx_off),
        .rx_avail  (rx_avail),
        .rx_full   (rx_full),
        .err_evt   ({rx_brk_evt, rx_frm_evt, rx_par_evt, rx_ovr_evt}),
        .brk_evt   (rx_brk_evt),
        .rx_en     (rx_en),
        .rx_rdy    (rx_rdy),
        .rx_ffull  (rx_ffull),
        .err_flags (err_flags),
        .brk_int   (brk_int),
        .rx_rst    (rx_rst)
    );

    // status and interrupt status bytes
    always_comb begin
        stat_byte = '0;
        stat_byte[ST_RXRDY] = rx_rdy;
        stat_byte[ST_FFULL] = rx_ffull;
        stat_byte[ST_TXRDY] = tx_rdy;
        stat_byte[ST_TXEMP] = tx_emp;
        stat_byte[ST_ERR0 +: ERR_N] = err_flags;

        isr_byte = '0;
        isr_byte[IS_TX]  = tx_rdy;
        isr_byte[IS_RX]  = s_q.mode[0][MR1_RXSEL] ? rx_ffull : rx_rdy;
        isr_byte[IS_BRK] = brk_int;
        isr_byte[IS_COS] = 1'b0;
    end

    // next-state of mode bytes, pointer, mask and flag
    always_comb begin
        s_d = s_q;
        if (bus_sel && hit_mode) begin
            if (bus_we) begin
                s_d.mode[s_q.ptr] = bus_wdata;
            end
            if (s_q.ptr != PTR_W'(MODE_N - 1)) begin
                s_d.ptr = s_q.ptr + 1'b1;
            end
        end
        if (wr && hit_int) begin
            s_d.imr = bus_wdata;
        end
        if (cmd_valid) begin
            if (dec.misc == MISC_PTRRST) begin
                s_d.ptr = '0;
            end
            if (dec.bad) begin
                s_d.bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (hit_mode) begin
                bus_rdata = s_q.mode[s_q.ptr];
            end else if (hit_stat) begin
                bus_rdata = DATA_W'(stat_byte);
            end else if (hit_data) begin
                bus_rdata = rx_head;
            end else if (hit_int) begin
                bus_rdata = DATA_W'(isr_byte);
            end
        end
    end

    assign rx_pop  = rd & hit_data;
    assign imr_q   = s_q.imr;
    assign irq     = |(DATA_W'(isr_byte) & s_q.imr);
    assign bad_cmd = s_q.bad;

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tx_load,
    input logic              tx_en,
    input logic              rx_pop,
    input logic              bad_cmd,
    input logic              irq,
    input logic [DATA_W-1:0] imr_q
);

    logic tx_wr;
    assign tx_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(6'h0C));

    // R3: a load completes in one cycle unless a new byte arrives
    a_r3_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !tx_wr) |=> !tx_load);

    // R3: a load never happens while the transmitter is disabled
    a_r3_load_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> tx_en);

    // R11: pop only on a read at the data offset
    a_r11_pop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (bus_sel && !bus_we && bus_addr == ADDR_W'(6'h0C)));

    // R5: the reserved-command flag is sticky
    a_r5_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |=> bad_cmd);

    // R10: no interrupt while every source is masked
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (imr_q == '0) |-> !irq);

endmodule

bind uart_regif uart_regif_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .tx_load  (tx_load),
    .tx_en    (tx_en),
    .rx_pop   (rx_pop),
    .bad_cmd  (bad_cmd),
    .irq      (irq),
    .imr_q    (imr_q)
);

// File: tb/uart_regif_bench.sv
`timescale 1ns/1ps
module uart_regif_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, tx_en, tx_load, tx_rst, rx_en, rx_rst, rx_pop, bad_cmd;
    logic [7:0] tx_data;
    logic [7:0] rx_head = '0;
    logic       rx_avail = 1'b0, rx_full = 1'b0;
    logic       rx_ovr_evt = 1'b0, rx_par_evt = 1'b0, rx_frm_evt = 1'b0, rx_brk_evt = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] rv;
    logic       pop_seen;

    always #2 clk = ~clk;

    uart_regif u_uart_regif (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_en(tx_en), .tx_load(tx_load), .tx_data(tx_data),
        .tx_rst(tx_rst), .rx_en(rx_en), .rx_rst(rx_rst), .rx_pop(rx_pop),
        .rx_head(rx_head), .rx_avail(rx_avail), .rx_full(rx_full),
        .rx_ovr_evt(rx_ovr_evt), .rx_par_evt(rx_par_evt),
        .rx_frm_evt(rx_frm_evt), .rx_brk_evt(rx_brk_evt), .bad_cmd(bad_cmd)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata; pop_seen = rx_pop;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic pulse_evt(input int which);
        @(negedge clk);
        case (which)
            0: rx_ovr_evt = 1'b1;
            1: rx_par_evt = 1'b1;
            2: rx_frm_evt = 1'b1;
            default: rx_brk_evt = 1'b1;
        endcase
        @(negedge clk);
        rx_ovr_evt = 1'b0; rx_par_evt = 1'b0; rx_frm_evt = 1'b0; rx_brk_evt = 1'b0;
    endtask

    function automatic logic [7:0] exp_isr(input logic txrdy, input logic sel_full,
                                           input logic av, input logic fu, input logic brk);
        return {5'b0, brk, (sel_full ? fu : av), txrdy};
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0x01 expected 0x00");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic m_tx, m_rx, m_bad;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(6'h04, rv); chk("R1 status", rv, 8'h08);
        rd(6'h14, rv); chk("R1 isr", rv, 8'h00);
        chk("R1 outputs", {3'b0, irq, tx_en, rx_en, bad_cmd, tx_load}, 8'h00);

        // R2 mode pointer
        wr(6'h00, 8'h11);
        wr(6'h00, 8'h22);
        wr(6'h00, 8'h33);
        wr(6'h08, 8'h10);
        rd(6'h00, rv); chk("R2 first after ptr reset", rv, 8'h11);
        rd(6'h00, rv); chk("R2 sticks on second", rv, 8'h33);
        rd(6'h00, rv); chk("R2 still second", rv, 8'h33);
        wr(6'h08, 8'h10); wr(6'h00, 8'h00);

        // R3 R4 transmit with enable
        wr(6'h08, 8'h04);
        chk("R5 tx enabled", {7'b0, tx_en}, 8'h01);
        rd(6'h04, rv); chk("R4 txrdy idle", rv & 8'h0C, 8'h0C);
        wr(6'h0C, 8'h5A);
        chk("R3 load strobe", {7'b0, tx_load}, 8'h01);
        chk("R3 tx data", tx_data, 8'h5A);
        @(posedge clk); #1;
        chk("R3 load one cycle", {7'b0, tx_load}, 8'h00);
        rd(6'h04, rv); chk("R3 empty again", rv & 8'h0C, 8'h0C);

        // R3 R7 disabled transmitter keeps byte; reset drops it
        wr(6'h08, 8'h08);
        wr(6'h0C, 8'hC3);
        chk("R3 no load disabled", {7'b0, tx_load}, 8'h00);
        rd(6'h04, rv); chk("R4 R3 pending disabled", rv & 8'h0C, 8'h00);
        wr(6'h08, 8'h04);
        chk("R3 load on enable", {tx_load, tx_data[6:0]}, {1'b1, 7'h43});
        @(posedge clk); #1;
        wr(6'h08, 8'h08);
        wr(6'h0C, 8'h77);
        wr(6'h08, 8'h30);
        chk("R7 pulse and disable", {6'b0, tx_rst, tx_en}, 8'h02);
        @(posedge clk); #1;
        chk("R7 pulse one cycle", {7'b0, tx_rst}, 8'h00);
        rd(6'h04, rv); chk("R7 empty not ready", rv & 8'h0C, 8'h08);
        wr(6'h08, 8'h04);
        chk("R7 byte dropped", {7'b0, tx_load}, 8'h00);

        // R6 receiver reset hold
        wr(6'h08, 8'h01);
        rx_avail = 1'b1; rx_full = 1'b1;
        rd(6'h04, rv); chk("R8 rx levels", rv & 8'h03, 8'h03);
        wr(6'h08, 8'h20);
        chk("R6 pulse and disable", {6'b0, rx_rst, rx_en}, 8'h02);
        rd(6'h04, rv); chk("R6 held low", rv & 8'h03, 8'h00);
        rx_avail = 1'b0; rx_full = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rx_avail = 1'b1;
        rd(6'h04, rv); chk("R6 hold released", rv & 8'h03, 8'h01);
        rx_avail = 1'b0;
        wr(6'h08, 8'h21);
        chk("R5 enable after misc", {7'b0, rx_en}, 8'h01);

        // R8 error flags
        for (int k = 0; k < 3; k++) pulse_evt(k);
        rd(6'h04, rv); chk("R8 sticky errors", rv & 8'hF0, 8'h70);
        wr(6'h08, 8'h40);
        rd(6'h04, rv); chk("R8 error reset", rv & 8'hF0, 8'h00);

        // R9 break
        wr(6'h14, 8'h04);
        pulse_evt(3);
        rd(6'h14, rv); chk("R9 break int", rv & 8'h04, 8'h04);
        chk("R10 irq on break", {7'b0, irq}, 8'h01);
        wr(6'h08, 8'h60); wr(6'h08, 8'h70); wr(6'h08, 8'h00);
        rd(6'h14, rv); chk("R9 misc 6 7 0 no effect", rv & 8'h04, 8'h04);
        wr(6'h08, 8'h50);
        rd(6'h14, rv); chk("R9 break cleared", rv & 8'h04, 8'h00);
        rd(6'h04, rv); chk("R9 rb bit kept", rv & 8'h80, 8'h80);
        wr(6'h08, 8'h40);

        // R11 pop and ignored writes
        rx_head = 8'hA5;
        rd(6'h0C, rv); chk("R11 head", rv, 8'hA5);
        chk("R11 pop", {7'b0, pop_seen}, 8'h01);
        rd(6'h04, rv); chk("R11 no pop elsewhere", {7'b0, pop_seen}, 8'h00);
        wr(6'h14, 8'h01);
        rd(6'h04, rv);
        wr(6'h04, 8'hFF); wr(6'h10, 8'hFF);
        begin
            logic [7:0] rv2;
            rd(6'h04, rv2); chk("R11 ignored writes status", rv2, rv);
        end
        chk("R11 irq kept", {7'b0, irq}, 8'h01);

        // R5 reserved codes
        wr(6'h08, 8'h0C);
        chk("R5 bad tx code", {6'b0, bad_cmd, tx_en}, 8'h03);

        // R5 random command model
        m_tx = tx_en; m_rx = rx_en; m_bad = 1'b1;
        for (int i = 0; i < 150; i++) begin
            logic [1:0] t, r, mi;
            logic [2:0] misc;
            t = 2'($urandom); r = 2'($urandom); mi = 2'($urandom % 3);
            misc = (mi == 0) ? 3'd0 : (mi == 1) ? 3'd6 : 3'd7;
            wr(6'h08, {1'b0, misc, t, r});
            if (t == 1) m_tx = 1'b1; else if (t == 2) m_tx = 1'b0;
            if (r == 1) m_rx = 1'b1; else if (r == 2) m_rx = 1'b0;
            chk("R5 random enables", {5'b0, bad_cmd, tx_en, rx_en}, {5'b0, m_bad, m_tx, m_rx});
            rd(6'h04, rv); chk("R4 random txrdy", rv & 8'h0C, {4'b0, 1'b1, m_tx, 2'b0});
        end

        // R10 random interrupt model
        for (int i = 0; i < 60; i++) begin
            logic [7:0] mask, ei;
            logic sel, t;
            mask = 8'($urandom); sel = 1'($urandom); t = 1'($urandom);
            wr(6'h08, 8'h10);
            wr(6'h00, {1'b0, sel, 6'h00});
            wr(6'h08, t ? 8'h04 : 8'h08);
            wr(6'h14, mask);
            rx_avail = 1'($urandom); rx_full = 1'($urandom);
            ei = exp_isr(t, sel, rx_avail, rx_full, 1'b0);
            rd(6'h14, rv); chk("R10 random isr", rv, ei);
            chk("R10 random irq", {7'b0, irq}, {7'b0, |(ei & mask)});
        end
        rx_avail = 1'b0; rx_full = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule